// File: doc/BRIEF.md
# Dual-Polynomial Multiple-Input Signature Register

This block compacts a parallel response word from a circuit under self-test into a single WIDTH-bit signature. On every cycle in which the valid strobe is high, the current word is folded into an internal-XOR shift register. Each stage takes the bit from the stage below it, adds the feedback from the top stage where that stage has a tap, and adds its own response bit. Because the update is linear, the final signature is the XOR of the signatures that each response lane would leave by itself.

Two feedback polynomials are built in, and a 2:1 multiplexer chooses between them. A test is run twice, once with each polynomial, so that an error pattern that aliases under one polynomial is unlikely to alias under the other. The polynomial choice is captured when the register is cleared to its all-zero seed, and it holds for the whole epoch. At the end of an epoch a done strobe compares the signature with the expected value for that epoch and records the result. An overall pass flag is raised only when both epochs have matched.

Top module: `dual_poly_misr`

## Requirements
- R1: While rst_ni is low and right after it is released, sig_o is all zeros and pass_a_o, pass_b_o and pass_o are 0.
- R2: A cycle with clear_i high leaves sig_o all zeros after that edge, even if valid_i is high in the same cycle.
- R3: A cycle with valid_i high and clear_i low sets sig_o to (S·x + D) mod P. Here bit i of the signature S and of resp_i D is the coefficient of x^i, and P is x^WIDTH plus the tap mask of the active polynomial (mask bit i = coefficient of x^i).
- R4: A cycle with valid_i and clear_i both low leaves sig_o unchanged.
- R5: poly_sel_i is sampled only in a clear cycle (0 selects POLY_A, 1 selects POLY_B). A change while clear_i is low has no effect until the next clear.
- R6: With the default POLY_A (x^5+x^3+x+1), feeding bit 0 with 1,0,0,0,1,0,1,0 after a clear leaves sig_o = 5'b01101 (1+x^2+x^3).
- R7: The signature of a multi-lane stream equals the XOR of the signatures of its lanes taken separately.
- R8: A done_i cycle sets the pass flag of the active epoch to (sig_o == that epoch's golden input) and leaves the other epoch's flag unchanged.
- R9: pass_o is 1 exactly when both pass_a_o and pass_b_o are 1.
- R10: When done_i and valid_i are high in the same cycle, the comparison uses the signature from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to the zero seed; captures poly_sel_i |
| valid_i | input | 1 | Fold resp_i into the signature this cycle |
| resp_i | input | WIDTH | Parallel response word |
| poly_sel_i | input | 1 | Feedback polynomial choice (0 = A, 1 = B) |
| done_i | input | 1 | End of epoch: compare and record the result |
| golden_a_i | input | WIDTH | Expected signature for the POLY_A epoch |
| golden_b_i | input | WIDTH | Expected signature for the POLY_B epoch |
| sig_o | output | WIDTH | Current signature |
| pass_a_o | output | 1 | Recorded result of the A epoch |
| pass_b_o | output | 1 | Recorded result of the B epoch |
| pass_o | output | 1 | Both epochs matched |

## Verification
The hardest case to set up is a select that changes in the middle of an epoch, because the register has to keep using the polynomial it latched. The bench clears with one select value and flips poly_sel_i after the first word. It then checks the final signature against the arithmetic remainder for the latched polynomial. The done-with-valid collision and the pass flag of one epoch holding while the other epoch is rerun are reached by running whole A and B epochs back to back, with deliberately wrong and then correct golden values.

// File: rtl/misr_pkg.sv
package misr_pkg;
  typedef enum logic {
    EPOCH_A = 1'b0,
    EPOCH_B = 1'b1
  } epoch_e;
endpackage

// File: rtl/misr_poly_sel.sv
module misr_poly_sel
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY_A = 5'b01011,
  parameter logic [WIDTH-1:0] POLY_B = 5'b00101
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             poly_sel_i,
  output epoch_e           epoch_o,
  output logic [WIDTH-1:0] taps_o
);
  epoch_e epoch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      epoch_q <= EPOCH_A;
    else if (clear_i) epoch_q <= epoch_e'(poly_sel_i);
  end

  // 2:1 feedback mux
  assign taps_o  = (epoch_q == EPOCH_B) ? POLY_B : POLY_A;
  assign epoch_o = epoch_q;

  p_sel_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $stable(epoch_q));
  p_sel_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (epoch_q == epoch_e'($past(poly_sel_i))));
endmodule

// File: rtl/misr_core.sv
module misr_core #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] resp_i,
  input  logic [WIDTH-1:0] taps_i,
  output logic [WIDTH-1:0] sig_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] sig_q, sig_d;
  logic             fb;

  assign fb = sig_q[TOP];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sig_d[i] = (taps_i[i] & fb) ^ resp_i[i];
    end else begin : g_rest
      assign sig_d[i] = sig_q[i-1] ^ (taps_i[i] & fb) ^ resp_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sig_q <= '0;
    else if (clear_i) sig_q <= '0;
    else if (valid_i) sig_q <= sig_d;
  end

  assign sig_o = sig_q;

  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (sig_q == '0));
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !valid_i) |=> $stable(sig_q));
  p_zero_stays_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && valid_i && sig_q == '0 && resp_i == '0) |=> (sig_q == '0));
  p_single_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && valid_i && sig_q == '0) |=> (sig_q == $past(resp_i)));
endmodule

// File: rtl/misr_sig_check.sv
module misr_sig_check
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  epoch_e           epoch_i,
  input  logic [WIDTH-1:0] sig_i,
  input  logic [WIDTH-1:0] golden_a_i,
  input  logic [WIDTH-1:0] golden_b_i,
  output logic             pass_a_o,
  output logic             pass_b_o,
  output logic             pass_o
);
  logic pass_a_q, pass_b_q;
  logic [WIDTH-1:0] golden;

  assign golden = (epoch_i == EPOCH_B) ? golden_b_i : golden_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_a_q <= 1'b0;
      pass_b_q <= 1'b0;
    end else if (done_i) begin
      if (epoch_i == EPOCH_A) pass_a_q <= (sig_i == golden);
      else                    pass_b_q <= (sig_i == golden);
    end
  end

  assign pass_a_o = pass_a_q;
  assign pass_b_o = pass_b_q;
  assign pass_o   = pass_a_q & pass_b_q;

  p_other_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && epoch_i == EPOCH_A) |=> $stable(pass_b_q));
  p_other_hold_b_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && epoch_i == EPOCH_B) |=> $stable(pass_a_q));
  p_no_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(pass_a_q) && $stable(pass_b_q)));
  p_overall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (pass_a_o && pass_b_o));
endmodule

// File: rtl/dual_poly_misr.sv
module dual_poly_misr
  import misr_pkg::*;
#(
  parameter int unsigned WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY_A = 5'b01011,
  parameter logic [WIDTH-1:0] POLY_B = 5'b00101
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] resp_i,
  input  logic             poly_sel_i,
  input  logic             done_i,
  input  logic [WIDTH-1:0] golden_a_i,
  input  logic [WIDTH-1:0] golden_b_i,
  output logic [WIDTH-1:0] sig_o,
  output logic             pass_a_o,
  output logic             pass_b_o,
  output logic             pass_o
);
  epoch_e           epoch;
  logic [WIDTH-1:0] taps;

  misr_poly_sel #(.WIDTH(WIDTH), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_sel (
    .clk_i, .rst_ni, .clear_i, .poly_sel_i,
    .epoch_o(epoch), .taps_o(taps)
  );

  misr_core #(.WIDTH(WIDTH)) u_core (
    .clk_i, .rst_ni, .clear_i, .valid_i, .resp_i,
    .taps_i(taps), .sig_o
  );

  misr_sig_check #(.WIDTH(WIDTH)) u_chk (
    .clk_i, .rst_ni, .done_i,
    .epoch_i(epoch), .sig_i(sig_o),
    .golden_a_i, .golden_b_i,
    .pass_a_o, .pass_b_o, .pass_o
  );

  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (sig_o == '0 || $past(rst_ni)));
  p_done_pre_update_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clear_i && epoch == EPOCH_A && sig_o == golden_a_i) |=> pass_a_o);
endmodule

// File: tb/sim_dual_poly_misr.sv
module sim_dual_poly_misr;
  localparam int W = 5;
  localparam logic [W-1:0] PA = 5'b01011;
  localparam logic [W-1:0] PB = 5'b00101;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0, valid_i = 1'b0, poly_sel_i = 1'b0, done_i = 1'b0;
  logic [W-1:0] resp_i = '0, golden_a_i = '0, golden_b_i = '0;
  logic [W-1:0] sig_o;
  logic pass_a_o, pass_b_o, pass_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  dual_poly_misr u0 (.*);

  function automatic logic [W-1:0] mdl(logic [W-1:0] s, logic [W-1:0] d, logic [W-1:0] p);
    logic [W-1:0] r;
    r = s << 1;
    if (s[W-1]) r = r ^ p;
    return r ^ d;
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_clear(logic sel);
    @(negedge clk_i);
    clear_i = 1'b1; poly_sel_i = sel;
    @(posedge clk_i); #1;
    clear_i = 1'b0;
  endtask

  task automatic feed(logic [W-1:0] d);
    @(negedge clk_i);
    valid_i = 1'b1; resp_i = d;
    @(posedge clk_i); #1;
    valid_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk_i);
    done_i = 1'b1;
    @(posedge clk_i); #1;
    done_i = 1'b0;
  endtask

  initial begin
    logic [W-1:0] e, sa, sb;
    logic [7:0] stream;
    #1;
    chk("R1 sig in reset", sig_o, '0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk("R1 sig after reset", sig_o, '0);
    chk("R1 pass flags after reset", {2'b0, pass_a_o, pass_b_o, pass_o}, '0);

    // R6 worked example, highest coefficient first on lane 0
    do_clear(1'b0);
    stream = 8'b1000_1010;
    for (int i = 7; i >= 0; i--) feed({4'b0, stream[i]});
    chk("R6 example remainder", sig_o, 5'b01101);

    // R3 sweep over every first word, both polynomials
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 32; d++) begin
        logic [W-1:0] d2;
        d2 = W'((d * 7 + 3) % 32);
        do_clear(p[0]);
        feed(W'(d));
        feed(d2);
        feed(W'(d ^ 5'b10110));
        e = mdl(mdl(mdl('0, W'(d), p[0] ? PB : PA), d2, p[0] ? PB : PA),
                W'(d ^ 5'b10110), p[0] ? PB : PA);
        chk("R3 update sweep", sig_o, e);
      end
    end

    // R4 idle cycles hold
    e = sig_o;
    @(negedge clk_i); resp_i = 5'b11111;
    repeat (3) @(posedge clk_i);
    #1 chk("R4 hold without valid", sig_o, e);

    // R2 clear wins over valid
    @(negedge clk_i); clear_i = 1'b1; valid_i = 1'b1; resp_i = 5'b10101;
    @(posedge clk_i); #1; clear_i = 1'b0; valid_i = 1'b0;
    chk("R2 clear priority", sig_o, '0);

    // R7 superposition of lanes
    do_clear(1'b1);
    for (int i = 0; i < 9; i++) feed({4'b0, i[0] ^ i[2]});
    sa = sig_o;
    do_clear(1'b1);
    for (int i = 0; i < 9; i++) feed({2'b0, i[1], 2'b0});
    sb = sig_o;
    do_clear(1'b1);
    for (int i = 0; i < 9; i++) feed({2'b0, i[1], 1'b0, i[0] ^ i[2]});
    chk("R7 linearity", sig_o, sa ^ sb);

    // R5 mid-epoch select change ignored
    do_clear(1'b0);
    e = '0;
    feed(5'b10011); e = mdl(e, 5'b10011, PA);
    @(negedge clk_i); poly_sel_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      feed(W'(i * 5 + 1)); e = mdl(e, W'(i * 5 + 1), PA);
    end
    chk("R5 select ignored mid-epoch", sig_o, e);
    do_clear(1'b1);
    e = '0;
    for (int i = 0; i < 6; i++) begin
      feed(W'(i * 5 + 1)); e = mdl(e, W'(i * 5 + 1), PB);
    end
    chk("R5 select taken at clear", sig_o, e);

    // R8 epoch A pass
    do_clear(1'b0);
    e = '0;
    for (int i = 0; i < 7; i++) begin
      feed(W'(i * 9 + 4)); e = mdl(e, W'(i * 9 + 4), PA);
    end
    golden_a_i = e;
    pulse_done();
    chk("R8 pass_a set", {4'b0, pass_a_o}, 5'd1);
    chk("R9 pass_o needs both", {4'b0, pass_o}, 5'd0);

    // R8 epoch B with wrong golden
    do_clear(1'b1);
    e = '0;
    for (int i = 0; i < 7; i++) begin
      feed(W'(i * 9 + 4)); e = mdl(e, W'(i * 9 + 4), PB);
    end
    golden_b_i = ~e;
    pulse_done();
    chk("R8 pass_b clear on mismatch", {4'b0, pass_b_o}, 5'd0);
    chk("R8 pass_a unchanged", {4'b0, pass_a_o}, 5'd1);

    // R10 done in same cycle as valid uses pre-update signature
    golden_b_i = e;
    @(negedge clk_i); done_i = 1'b1; valid_i = 1'b1; resp_i = 5'b00111;
    @(posedge clk_i); #1; done_i = 1'b0; valid_i = 1'b0;
    chk("R10 pre-update compare", {4'b0, pass_b_o}, 5'd1);
    chk("R10 signature still updated", sig_o, mdl(e, 5'b00111, PB));
    chk("R9 pass_o both", {4'b0, pass_o}, 5'd1);

    // R8 failing rerun of A drops overall
    do_clear(1'b0);
    feed(5'b00001);
    golden_a_i = 5'b00000;
    pulse_done();
    chk("R8 pass_a cleared on mismatch", {4'b0, pass_a_o}, 5'd0);
    chk("R9 pass_o dropped", {4'b0, pass_o}, 5'd0);
    chk("R8 pass_b kept", {4'b0, pass_b_o}, 5'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule